// File: doc/BRIEF.md
# Video Line and Frame Sequencer

This block turns the system clock into scanline and frame timing for a video subsystem. A clock divider produces one line tick per scanline period. A line counter advances on each tick. It raises a vertical-blank level at a fixed line. At the end of the frame it returns to line zero, drops vertical blank and issues a one-cycle vertical-sync interrupt pulse. A second counter, also advanced by line ticks, emits an audio-service strobe after a fixed number of scanlines.

One input chooses between two full sets of timing constants: 60 Hz (`mode_pal` = 0) and 50 Hz (`mode_pal` = 1). The divide value for each mode is computed at elaboration from the `CLK_HZ` parameter. A change on `mode_pal` is taken up only at a frame wrap, so a frame never mixes the two timings. Reset is asynchronous and active-low, and its release is synchronised inside the block.

Top module: `video_frame_seq`

## Requirements
- R1: While `rst_n` is low, `line_tick`, `vblank`, `vsync_irq` and `audio_strobe` are 0 and `line_num` is 0. After release the block runs in 60 Hz timing until the first frame wrap, whatever `mode_pal` is.
- R2: `line_tick` is a one-cycle pulse. Consecutive pulses are exactly DIV clock cycles apart, with DIV = floor(CLK_HZ / (60 × 263)) in 60 Hz timing and floor(CLK_HZ / (50 × 313)) in 50 Hz timing.
- R3: In the cycle after each `line_tick` pulse, `line_num` becomes its previous value plus one, or 0 on a wrap. Without a tick it holds its value.
- R4: `vblank` rises in the cycle in which `line_num` becomes 240 in 60 Hz timing, or 256 in 50 Hz timing.
- R5: When the incremented line would equal the frame length (263 lines in 60 Hz, 313 lines in 50 Hz), `line_num` becomes 0, `vblank` falls and `vsync_irq` is high for exactly that one cycle.
- R6: `audio_strobe` pulses for one cycle, aligned with the line update, on every 23rd line tick in 60 Hz timing and every 22nd in 50 Hz timing. Its count runs on across frame boundaries. If the count already meets a shorter interval after a mode switch, the strobe comes on the next tick.
- R7: `mode_pal` is sampled only at a frame wrap. A change in the middle of a frame alters neither the line period, the blank line nor the frame length of the current frame.
- R8: `line_num` never exceeds the frame length of the active timing minus one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_pal | input | 1 | Requested timing: 0 = 60 Hz, 1 = 50 Hz |
| line_tick | output | 1 | One-cycle pulse at each scanline boundary |
| line_num | output | 9 | Current scanline number |
| vblank | output | 1 | High during vertical blank |
| vsync_irq | output | 1 | One-cycle pulse at the frame wrap |
| audio_strobe | output | 1 | One-cycle audio-service pulse |

## Verification
On every cycle, the bound assertions check the local rules. A pulse never lasts two cycles. The line number only steps by one or wraps, and only after a tick. Blank starts only on the mode's blank line. The sync pulse coincides with line zero and blank off. The latched timing changes only at a wrap. The line number stays in range. The exact tick spacing per mode, the count of 23 or 22 lines between audio strobes, the ignoring of a mid-frame mode change and the 60 Hz start after reset all depend on long histories. Only the bench's cycle-accurate reference model across whole frames in both timings can show these.

// File: rtl/vfs_pkg.sv
package vfs_pkg;

  typedef enum logic {
    TM_60 = 1'b0,
    TM_50 = 1'b1
  } tmode_e;

  localparam int unsigned RATE_60  = 60;
  localparam int unsigned RATE_50  = 50;
  localparam int unsigned LINES_60 = 263;
  localparam int unsigned LINES_50 = 313;
  localparam int unsigned VBL_60   = 240;
  localparam int unsigned VBL_50   = 256;
  localparam int unsigned AUD_60   = 23;
  localparam int unsigned AUD_50   = 22;

  localparam int unsigned LINES_MAX = (LINES_60 > LINES_50) ? LINES_60 : LINES_50;
  localparam int unsigned AUD_MAX   = (AUD_60 > AUD_50) ? AUD_60 : AUD_50;
  localparam int unsigned LINE_W    = $clog2(LINES_MAX);
  localparam int unsigned AUD_W     = $clog2(AUD_MAX + 1);

  function automatic int unsigned lines_of(tmode_e m);
    return (m == TM_50) ? LINES_50 : LINES_60;
  endfunction

  function automatic int unsigned vbl_of(tmode_e m);
    return (m == TM_50) ? VBL_50 : VBL_60;
  endfunction

  function automatic int unsigned aud_of(tmode_e m);
    return (m == TM_50) ? AUD_50 : AUD_60;
  endfunction

endpackage

// File: rtl/vfs_rst_sync.sv
module vfs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/vfs_line_div.sv
module vfs_line_div
  import vfs_pkg::*;
#(
  parameter int unsigned CLK_HZ = 33868800
) (
  input  logic   clk,
  input  logic   rst_n,
  input  tmode_e mode,
  output logic   tick
);
  localparam int unsigned DIV_60  = CLK_HZ / (RATE_60 * LINES_60);
  localparam int unsigned DIV_50  = CLK_HZ / (RATE_50 * LINES_50);
  localparam int unsigned DIV_MAX = (DIV_60 > DIV_50) ? DIV_60 : DIV_50;
  localparam int unsigned CNT_W   = $clog2(DIV_MAX + 1);
  localparam logic [CNT_W-1:0] LAST_60 = CNT_W'(DIV_60 - 1);
  localparam logic [CNT_W-1:0] LAST_50 = CNT_W'(DIV_50 - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tick_q, tick_d;
  logic [CNT_W-1:0] last;

  always_comb begin
    last   = (mode == TM_50) ? LAST_50 : LAST_60;
    cnt_d  = cnt_q + CNT_W'(1);
    tick_d = 1'b0;
    if (cnt_q >= last) begin
      cnt_d  = '0;
      tick_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q;
endmodule

// File: rtl/vfs_line_ctr.sv
module vfs_line_ctr
  import vfs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  tmode_e            mode_req,
  output logic [LINE_W-1:0] line_num,
  output logic              vblank,
  output logic              vsync_irq,
  output tmode_e            act_mode
);
  logic [LINE_W-1:0] line_q, line_d, line_inc, last_line, vbl_line;
  logic              vbl_q, vbl_d;
  logic              vs_q, vs_d;
  tmode_e            mode_q, mode_d;

  always_comb begin
    last_line = LINE_W'(lines_of(mode_q));
    vbl_line  = LINE_W'(vbl_of(mode_q));
    line_inc  = line_q + LINE_W'(1);
    line_d    = line_q;
    vbl_d     = vbl_q;
    vs_d      = 1'b0;
    mode_d    = mode_q;
    if (tick) begin
      if (line_inc == last_line) begin
        line_d = '0;
        vbl_d  = 1'b0;
        vs_d   = 1'b1;
        mode_d = mode_req;
      end else begin
        line_d = line_inc;
        if (line_inc == vbl_line) vbl_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      vbl_q  <= 1'b0;
      vs_q   <= 1'b0;
      mode_q <= TM_60;
    end else begin
      line_q <= line_d;
      vbl_q  <= vbl_d;
      vs_q   <= vs_d;
      mode_q <= mode_d;
    end
  end

  assign line_num  = line_q;
  assign vblank    = vbl_q;
  assign vsync_irq = vs_q;
  assign act_mode  = mode_q;
endmodule

// File: rtl/vfs_audio_ctr.sv
module vfs_audio_ctr
  import vfs_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick,
  input  tmode_e mode,
  output logic   strobe
);
  logic [AUD_W-1:0] acnt_q, acnt_d, acnt_inc, interval;
  logic             stb_q, stb_d;

  always_comb begin
    interval = AUD_W'(aud_of(mode));
    acnt_inc = acnt_q + AUD_W'(1);
    acnt_d   = acnt_q;
    stb_d    = 1'b0;
    if (tick) begin
      if (acnt_inc >= interval) begin
        acnt_d = '0;
        stb_d  = 1'b1;
      end else begin
        acnt_d = acnt_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acnt_q <= '0;
      stb_q  <= 1'b0;
    end else begin
      acnt_q <= acnt_d;
      stb_q  <= stb_d;
    end
  end

  assign strobe = stb_q;
endmodule

// File: rtl/video_frame_seq.sv
module video_frame_seq
  import vfs_pkg::*;
#(
  parameter int unsigned CLK_HZ = 33868800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_pal,
  output logic              line_tick,
  output logic [LINE_W-1:0] line_num,
  output logic              vblank,
  output logic              vsync_irq,
  output logic              audio_strobe
);
  logic   srst_n;
  logic   tick;
  tmode_e act_mode;
  tmode_e mode_req;

  assign mode_req = mode_pal ? TM_50 : TM_60;

  vfs_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  vfs_line_div #(.CLK_HZ(CLK_HZ)) u_div (
    .clk   (clk),
    .rst_n (srst_n),
    .mode  (act_mode),
    .tick  (tick)
  );

  vfs_line_ctr u_line (
    .clk       (clk),
    .rst_n     (srst_n),
    .tick      (tick),
    .mode_req  (mode_req),
    .line_num  (line_num),
    .vblank    (vblank),
    .vsync_irq (vsync_irq),
    .act_mode  (act_mode)
  );

  vfs_audio_ctr u_aud (
    .clk    (clk),
    .rst_n  (srst_n),
    .tick   (tick),
    .mode   (act_mode),
    .strobe (audio_strobe)
  );

  assign line_tick = tick;
endmodule

// File: rtl/vfs_seq_checker.sv
module vfs_seq_checker
  import vfs_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              line_tick,
  input logic [LINE_W-1:0] line_num,
  input logic              vblank,
  input logic              vsync_irq,
  input logic              audio_strobe,
  input tmode_e            act_mode
);
  assert_tick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    line_tick |=> !line_tick);

  assert_line_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(line_tick) |-> (line_num == $past(line_num) + LINE_W'(1) || line_num == '0));

  assert_line_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(line_tick) |-> $stable(line_num));

  assert_vbl_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vblank) |-> ((act_mode == TM_60 && line_num == LINE_W'(VBL_60)) ||
                       (act_mode == TM_50 && line_num == LINE_W'(VBL_50))));

  assert_wrap_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vsync_irq |-> (line_num == '0 && !vblank));

  assert_vsync_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vsync_irq |=> !vsync_irq);

  assert_vbl_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vblank) |-> vsync_irq);

  assert_audio_after_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    audio_strobe |-> $past(line_tick));

  assert_mode_at_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_mode) |-> vsync_irq);

  assert_line_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    line_num < ((act_mode == TM_50) ? LINE_W'(LINES_50) : LINE_W'(LINES_60)));
endmodule

bind video_frame_seq vfs_seq_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .line_tick    (line_tick),
  .line_num     (line_num),
  .vblank       (vblank),
  .vsync_irq    (vsync_irq),
  .audio_strobe (audio_strobe),
  .act_mode     (act_mode)
);

// File: tb/tb_video_frame_seq.sv
module tb_video_frame_seq;
  localparam int unsigned TB_CLK_HZ = 1972500;
  localparam int P60 = 125;  // floor(1972500 / 15780)
  localparam int P50 = 126;  // floor(1972500 / 15650)
  localparam int NSTEP = 5;
  localparam int STEP_MODE [NSTEP] = '{0, 1, 1, 1, 0};
  localparam int STEP_TICKS[NSTEP] = '{250, 5, 20, 300, 40};
  localparam int STEP_LINE [NSTEP] = '{250, 255, 12, 312, 39};
  localparam int STEP_VBL  [NSTEP] = '{1, 1, 0, 1, 0};

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_pal;
  logic       line_tick;
  logic [8:0] line_num;
  logic       vblank;
  logic       vsync_irq;
  logic       audio_strobe;

  int checks = 0;
  int errors = 0;
  bit mon_on = 1'b0;

  int m_line, m_vb, m_vs, m_au, m_acnt, m_mode, m_period, nl;
  int cyc, last_cyc;
  bit have_last;

  always #2 clk = ~clk;

  video_frame_seq #(.CLK_HZ(TB_CLK_HZ)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_pal     (mode_pal),
    .line_tick    (line_tick),
    .line_num     (line_num),
    .vblank       (vblank),
    .vsync_irq    (vsync_irq),
    .audio_strobe (audio_strobe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_line = 0; m_vb = 0; m_vs = 0; m_au = 0; m_acnt = 0; m_mode = 0;
    m_period = P60; have_last = 1'b0; cyc = 0; last_cyc = 0;
  endtask

  // Cycle-accurate reference model, compared on every falling edge.
  always @(negedge clk) begin
    if (mon_on) begin
      cyc++;
      chk(int'(line_num) == m_line, "R3 line_num", int'(line_num), m_line);
      chk(int'(vblank) == m_vb, "R4 vblank", int'(vblank), m_vb);
      chk(int'(vsync_irq) == m_vs, "R5 vsync_irq", int'(vsync_irq), m_vs);
      chk(int'(audio_strobe) == m_au, "R6 audio_strobe", int'(audio_strobe), m_au);
      if (line_tick) begin
        if (have_last) chk(cyc - last_cyc == m_period, "R2 tick spacing", cyc - last_cyc, m_period);
        have_last = 1'b1;
        last_cyc  = cyc;
        if (m_acnt + 1 >= ((m_mode != 0) ? 22 : 23)) begin
          m_au = 1; m_acnt = 0;
        end else begin
          m_au = 0; m_acnt++;
        end
        nl   = m_line + 1;
        m_vs = 0;
        if (nl == ((m_mode != 0) ? 313 : 263)) begin
          nl = 0; m_vb = 0; m_vs = 1; m_mode = int'(mode_pal);
        end else if (nl == ((m_mode != 0) ? 256 : 240)) begin
          m_vb = 1;
        end
        m_line   = nl;
        m_period = (m_mode != 0) ? P50 : P60;
      end else begin
        m_vs = 0;
        m_au = 0;
      end
    end
  end

  task automatic wait_ticks(input int n);
    int seen = 0;
    while (seen < n) begin
      @(negedge clk);
      if (line_tick) seen++;
    end
    @(negedge clk);
  endtask

  initial begin
    #760000;
    errors++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    mode_pal = 1'b0;
    repeat (3) @(negedge clk);
    chk(line_num == 9'd0, "R1 reset line_num", int'(line_num), 0);
    chk({line_tick, vblank, vsync_irq, audio_strobe} == 4'b0, "R1 reset pulses",
        int'({line_tick, vblank, vsync_irq, audio_strobe}), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    model_reset();
    mon_on = 1'b1;

    // Table walk: mode request, ticks to run, expected position afterwards.
    for (int s = 0; s < NSTEP; s++) begin
      @(posedge clk); #1;
      mode_pal = STEP_MODE[s][0];
      wait_ticks(STEP_TICKS[s]);
      chk(int'(line_num) == STEP_LINE[s], "R7 line after step", int'(line_num), STEP_LINE[s]);
      chk(int'(vblank) == STEP_VBL[s], "R4 vblank after step", int'(vblank), STEP_VBL[s]);
      chk(int'(line_num) < ((m_mode != 0) ? 313 : 263), "R8 range", int'(line_num), 0);
    end

    // Reset in mid-frame with 50 Hz requested: outputs clear, then 60 Hz timing.
    @(posedge clk); #1;
    mode_pal = 1'b1;
    mon_on   = 1'b0;
    rst_n    = 1'b0;
    @(negedge clk);
    chk(line_num == 9'd0, "R1 mid reset line_num", int'(line_num), 0);
    chk({line_tick, vblank, vsync_irq, audio_strobe} == 4'b0, "R1 mid reset pulses",
        int'({line_tick, vblank, vsync_irq, audio_strobe}), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    model_reset();
    mon_on = 1'b1;
    wait_ticks(30);
    chk(int'(line_num) == 30, "R1 line after restart", int'(line_num), 30);
    chk(m_period == P60, "R1 60 Hz after reset", m_period, P60);

    mon_on = 1'b0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule